// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block keeps the 32-bit program counter of a single-cycle processor and works out its next value on every clock edge. The current PC goes as the address to a small internal instruction store that is addressed by word. The 32-bit instruction word found there appears on the output in the same cycle.

Two control inputs from the datapath decide where execution goes next. One is a branch-select signal from the decoder. The other is an equality flag from the register comparison. When both are high, the PC moves to a target relative to the PC, formed from the low 16 bits of the current instruction. In every other case the PC steps to the next word.

The instruction store has no write port. It holds a computed pattern, so the fetched word and the branch offsets are known in advance at every address. A synchronous reset sends the PC back to address zero.

Top module: `ifetch_npc`

## Requirements
- R1: When `rst` is high at a rising clock edge, the PC becomes 0x00000000. This holds whatever the values of `br_sel` and `eq_flag` are.
- R2: `instr_o` shows the store word at index i = `pc_o[IDX_W+1:2]` in the same cycle, with no clock edge in between. Word i is defined as follows, where i is zero-extended to 16 bits: bits [31:16] are 0xC0DE XOR i, and bits [15:0] are (i mod 8) - 4 in 16-bit two's complement.
- R3: When `rst` is low and `br_sel` is low, the next PC is PC + 4. This holds whatever the value of `eq_flag` is.
- R4: When `eq_flag` is high and `br_sel` is low, the PC still advances by exactly 4. The equality flag alone has no effect.
- R5: When `br_sel` and `eq_flag` are both high, the next PC is PC + 4 + (sign-extended `instr_o[15:0]` × 4).
- R6: All PC arithmetic wraps modulo 2^32, and no fault is raised. For example, a backward branch taken at PC 0 lands near 0xFFFFFFFF, and stepping forward from 0xFFFFFFFC gives 0x00000000.
- R7: Only PC bits [IDX_W+1:2] select the store word. The two low bits and all bits above IDX_W+1 are ignored, so high addresses alias onto the store.
- R8: PC bits [1:0] remain zero at all times after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Selects the branch path for the next address |
| eq_flag | input | 1 | Equality result from the register comparison |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word fetched at `pc_o` |

## Verification
Two functions can fall in the same cycle: reset, and a taken branch with both control inputs high. The bench provokes this by raising `rst` together with `br_sel` and `eq_flag` while the PC is not zero. It judges the outcome by requiring the PC to be exactly zero one edge later.

A second overlap comes from a taken backward branch at PC 0. That single step both takes the branch and wraps the arithmetic. The bench checks that it lands on 0xFFFFFFF4, and that the aliased store word fetched there is the one at index 61.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
   localparam int XLEN  = 32;
   localparam int IMM_W = 16;

   typedef logic [XLEN-1:0]  addr_t;
   typedef logic [XLEN-1:0]  word_t;
   typedef logic [IMM_W-1:0] imm_t;

   // Store contents: tag in the upper half, small signed word offset below.
   function automatic word_t store_word(input int unsigned idx);
      logic [15:0] tag;
      logic [15:0] off;
      tag = 16'hC0DE ^ idx[15:0];
      off = {13'd0, idx[2:0]} - 16'd4;
      return {tag, off};
   endfunction

   // Branch displacement in bytes: sign extend, then scale by four.
   function automatic addr_t scale_offset(input imm_t imm);
      return {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
   endfunction
endpackage

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg
   import ifu_pkg::*;
#(
   parameter addr_t RESET_PC = '0
) (
   input  logic  clk,
   input  logic  rst,
   input  addr_t npc,
   output addr_t pc
);
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
      $error("ifu_pc_reg: reset address must be word aligned");
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_PC;
      else     pc <= npc;
   end

   // R1: reset wins over any next-address request
   a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc == RESET_PC);

   // R8: alignment is preserved across updates
   a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> pc[1:0] == 2'b00);
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem
   import ifu_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0] idx,
   output word_t            word
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ifu_imem: DEPTH must be a power of two of at least 2");
   end
   if (DEPTH > 4096) begin : g_too_deep
      $error("ifu_imem: DEPTH too large for a computed store");
   end

   word_t rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_fill
      assign rom[g] = store_word(g);
   end

   always_comb word = rom[idx];

   // R2: every word carries its index in the tag field
   always_comb begin
      a_r2_tag: assert (word[31:16] == (16'hC0DE ^ 16'(idx)));
   end
endmodule

// File: rtl/ifu_next_addr.sv
module ifu_next_addr
   import ifu_pkg::*;
#(
   // 0: sequential adder followed by target adder; 1: one merged sum
   parameter int TGT_STYLE = 0
) (
   input  addr_t pc,
   input  imm_t  imm,
   input  logic  take,
   output addr_t npc
);
   if (TGT_STYLE != 0 && TGT_STYLE != 1) begin : g_bad_style
      $error("ifu_next_addr: TGT_STYLE must be 0 or 1");
   end

   addr_t seq_pc;
   addr_t tgt_pc;
   addr_t disp;

   assign disp   = scale_offset(imm);
   assign seq_pc = pc + addr_t'(4);

   if (TGT_STYLE == 0) begin : g_chain
      assign tgt_pc = seq_pc + disp;
   end else begin : g_merged
      assign tgt_pc = pc + disp + addr_t'(4);
   end

   assign npc = take ? tgt_pc : seq_pc;

   // R3/R4: an untaken path steps exactly one word
   always_comb begin
      a_r3_seq_step: assert (take || (npc - pc) == addr_t'(4));
   end
endmodule

// File: rtl/ifetch_npc.sv
module ifetch_npc
   import ifu_pkg::*;
#(
   parameter int    DEPTH     = 64,
   parameter int    TGT_STYLE = 0,
   parameter addr_t RESET_PC  = '0,
   localparam int   IDX_W     = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        br_sel,
   input  logic        eq_flag,
   output logic [31:0] pc_o,
   output logic [31:0] instr_o
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("ifetch_npc: word width must be 32");
   end
   if (IDX_W + 2 > XLEN) begin : g_bad_idx
      $error("ifetch_npc: store index exceeds address width");
   end

   addr_t pc_q;
   addr_t npc;
   word_t instr;
   logic  take;

   assign take = br_sel & eq_flag;

   ifu_pc_reg #(.RESET_PC(RESET_PC)) u_pc (
      .clk (clk),
      .rst (rst),
      .npc (npc),
      .pc  (pc_q)
   );

   ifu_imem #(.DEPTH(DEPTH)) u_imem (
      .idx  (pc_q[IDX_W+1:2]),
      .word (instr)
   );

   ifu_next_addr #(.TGT_STYLE(TGT_STYLE)) u_nxt (
      .pc   (pc_q),
      .imm  (instr[IMM_W-1:0]),
      .take (take),
      .npc  (npc)
   );

   assign pc_o    = pc_q;
   assign instr_o = instr;

   // R3: branch select low means a one-word step, modulo 2^32 (R6)
   a_r3_seq: assert property (@(posedge clk) disable iff (rst)
      !br_sel |=> pc_o == $past(pc_o) + 32'd4);

   // R4: equality flag alone has no effect
   a_r4_eq_alone: assert property (@(posedge clk) disable iff (rst)
      (eq_flag && !br_sel) |=> pc_o == $past(pc_o) + 32'd4);

   // R5: taken branch lands on the scaled relative target
   a_r5_taken: assert property (@(posedge clk) disable iff (rst)
      (br_sel && eq_flag) |=> pc_o == $past(pc_o) + 32'd4
         + {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00});

   // R7: store index ignores address bits outside the word index
   a_r7_alias: assert property (@(posedge clk) disable iff (rst)
      $stable(pc_o[IDX_W+1:2]) |-> $stable(instr_o));
endmodule

// File: tb/ifetch_npc_bench.sv
module ifetch_npc_bench;
   localparam int DEPTH = 64;
   localparam int NV    = 16;
   // each entry: {br_sel, eq_flag}
   localparam logic [1:0] VEC [NV] = '{
      2'b00, 2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b11, 2'b10,
      2'b01, 2'b11, 2'b00, 2'b00, 2'b11, 2'b01, 2'b11, 2'b00};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        br_sel = 1'b0;
   logic        eq_flag = 1'b0;
   logic [31:0] pc_o, instr_o;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ifetch_npc u_ifetch_npc (
      .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag),
      .pc_o(pc_o), .instr_o(instr_o));

   function automatic logic [31:0] exp_word(input logic [31:0] pc);
      logic [5:0] i;
      i = pc[7:2];
      return {16'hC0DE ^ {10'd0, i}, {13'd0, i[2:0]} - 16'd4};
   endfunction

   function automatic logic [31:0] exp_next(input logic [31:0] pc,
                                            input logic s, input logic e);
      logic [15:0] o;
      o = exp_word(pc)[15:0];
      return pc + 32'd4 + ((s && e) ? {{14{o[15]}}, o, 2'b00} : 32'd0);
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic s, input logic e, input string req,
                       inout logic [31:0] m_pc);
      br_sel = s; eq_flag = e; rst = 1'b0;
      m_pc = exp_next(m_pc, s, e);
      @(negedge clk);
      check(req, pc_o, m_pc);
      check("R2 fetch", instr_o, exp_word(m_pc));
   endtask

   initial begin
      logic [31:0] m_pc;
      repeat (2) @(negedge clk);
      check("R1 reset pc", pc_o, 32'h0);
      check("R2 reset fetch", instr_o, exp_word(32'h0));
      m_pc = 32'h0;
      for (int k = 0; k < NV; k++) begin
         step(VEC[k][1], VEC[k][0],
              VEC[k] == 2'b11 ? "R5 taken" :
              VEC[k] == 2'b01 ? "R4 eq alone" : "R3 sequential", m_pc);
         check("R8 aligned", {30'd0, pc_o[1:0]}, 32'h0);
      end
      // R1: reset with a taken branch pending in the same cycle
      if (pc_o == 32'h0) step(1'b0, 1'b0, "R3 sequential", m_pc);
      rst = 1'b1; br_sel = 1'b1; eq_flag = 1'b1;
      @(negedge clk);
      check("R1 reset beats branch", pc_o, 32'h0);
      m_pc = 32'h0;
      // R6: backward branch at zero wraps; R7: high address aliases to 61
      step(1'b1, 1'b1, "R6 wrap backward", m_pc);
      check("R6 wrap value", pc_o, 32'hFFFF_FFF4);
      check("R7 alias word", instr_o, {16'hC0DE ^ 16'd61, 16'd1});
      step(1'b0, 1'b1, "R4 eq alone high", m_pc);
      step(1'b0, 1'b0, "R3 sequential high", m_pc);
      step(1'b0, 1'b0, "R6 wrap forward", m_pc);
      check("R6 wrap to zero", pc_o, 32'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule